// File: doc/BRIEF.md
# Pulse-Width Bit Discriminator Latch

This block turns a serial stream of single-bit pulses into a persistent on/off state for one light. Each pulse carries one bit in its width: a short pulse means off, a long pulse means on. The rising edge of a pulse opens a timing window of fixed length, measured in clock cycles. Whichever ends first, the pulse or the window, gives the bit. A pulse that drops low inside the window reads as 0. A pulse that is still high when the window closes reads as 1.

The decision goes into the output register in the same cycle it is made, and that value holds until the next decision. There is no separate latch or strobe phase. The window cannot be restarted while it runs. Glitches shorter than a minimum width are thrown away without touching the state. A one-cycle strobe with the decoded bit comes out alongside the state, so a neighbouring block can count or log decisions.

The input is asynchronous to the clock and passes through a parameterised synchronizer. Every timing figure below counts cycles at the last synchronizer stage.

Top module: `pulse_bit_decoder`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears ledOn and bitValid to 0 and returns the decoder to waiting for a rising edge.
- R2: A pulse that is high for W sampled cycles with MIN_CYCLES <= W <= REF_CYCLES decodes as 0. bitValue is 0 and ledOn becomes 0.
- R3: A pulse still high REF_CYCLES cycles after its sampled rising edge decodes as 1, which means W > REF_CYCLES. The rest of that pulse causes no further decision.
- R4: A pulse with W < MIN_CYCLES is ignored. It produces no bitValid strobe and leaves ledOn unchanged.
- R5: Rising edges that arrive before the window of a decoded 0 has closed are ignored. This includes a pulse that begins inside the window and is still high when the window closes. Only the first falling edge decides the bit.
- R6: ledOn changes in the same cycle that bitValid pulses, and bitValid lasts exactly one cycle. Latency is counted from the first clock edge that samples pulseIn high. A 1 appears after SYNC_STAGES+REF_CYCLES edges. A 0 appears after SYNC_STAGES+W edges.
- R7: Between decisions ledOn holds its value indefinitely, with no drift or timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pulseIn | input | 1 | Asynchronous pulse stream addressed to this node |
| ledOn | output | 1 | Latched light state, 1 = on |
| bitValid | output | 1 | One-cycle strobe marking a committed decision |
| bitValue | output | 1 | Bit decoded in the strobe cycle |

## Verification
The bench drives pulses well inside each class: long pulses read as 1, medium ones as 0, and runts as nothing. It also drives pulses at the exact edges, where W = REF_CYCLES must differ from W = REF_CYCLES+1 and W = MIN_CYCLES must differ from W = MIN_CYCLES-1. Two-pulse patterns separate a second pulse that lies wholly inside a 0-window from one that starts inside the window and runs past it; both must vanish. A single-edge timing pattern separates immediate update from any delayed or double strobe. A long idle stretch shows that the state does not decay.

// File: rtl/pulse_bit_pkg.sv
package pulse_bit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_MEASURE = 2'd1,
    ST_HOLD    = 2'd2
  } decState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic winStart;  // load window counter with 1
    logic winStep;   // advance window counter
    logic commit;    // write a decision this cycle
    logic bitVal;    // value being written
  } decCtl_t;

endpackage

// File: rtl/pulse_bit_datapath.sv
module pulse_bit_datapath
  import pulse_bit_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REF_CYCLES  = 60,
  parameter int MIN_CYCLES  = 10
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    pulseIn,
  input  decCtl_t ctl,
  output logic    lvl,
  output logic    rise,
  output logic    cntAtRef,
  output logic    cntGeMin,
  output logic    ledOn,
  output logic    bitValid,
  output logic    bitValue
);

  localparam int CNT_W = $clog2(REF_CYCLES + 1);
  localparam logic [CNT_W-1:0] REF_CNT = CNT_W'(REF_CYCLES);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_CYCLES);
  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   lvlPrev;
  logic [CNT_W-1:0]       winCnt;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) syncChain[0] <= 1'b0;
        else     syncChain[0] <= pulseIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) syncChain[i] <= 1'b0;
        else     syncChain[i] <= syncChain[i-1];
      end
    end
  end

  assign lvl = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) lvlPrev <= 1'b0;
    else     lvlPrev <= lvl;
  end

  assign rise = lvl & ~lvlPrev;

  always_ff @(posedge clk) begin
    if (rst)               winCnt <= '0;
    else if (ctl.winStart) winCnt <= ONE_CNT;
    else if (ctl.winStep)  winCnt <= winCnt + ONE_CNT;
  end

  assign cntAtRef = (winCnt == REF_CNT);
  assign cntGeMin = (winCnt >= MIN_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ledOn    <= 1'b0;
      bitValid <= 1'b0;
      bitValue <= 1'b0;
    end else begin
      bitValid <= ctl.commit;
      if (ctl.commit) begin
        ledOn    <= ctl.bitVal;
        bitValue <= ctl.bitVal;
      end
    end
  end

  // R5: window counter never runs past the reference length
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    winCnt <= REF_CNT);

  // R7: without a commit the light state does not move
  assert_led_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !ctl.commit |=> $stable(ledOn));

  // R6: strobe is a single cycle
  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
    bitValid |=> !bitValid);

endmodule

// File: rtl/pulse_bit_control.sv
module pulse_bit_control
  import pulse_bit_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    lvl,
  input  logic    rise,
  input  logic    cntAtRef,
  input  logic    cntGeMin,
  output decCtl_t ctl
);

  decState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (rise) begin
          ctl.winStart = 1'b1;
          stateNext    = ST_MEASURE;
        end
      end
      ST_MEASURE: begin
        if (!lvl) begin
          if (cntGeMin) begin
            ctl.commit = 1'b1;
            ctl.bitVal = 1'b0;
            if (cntAtRef) begin
              stateNext = ST_IDLE;
            end else begin
              ctl.winStep = 1'b1;
              stateNext   = ST_HOLD;
            end
          end else begin
            stateNext = ST_IDLE;   // runt: dropped
          end
        end else if (cntAtRef) begin
          ctl.commit = 1'b1;
          ctl.bitVal = 1'b1;
          stateNext  = ST_IDLE;
        end else begin
          ctl.winStep = 1'b1;
        end
      end
      ST_HOLD: begin
        if (cntAtRef) stateNext = ST_IDLE;
        else          ctl.winStep = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R3: a 1 is only committed while the input is high at window end
  assert_one_at_ref_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl.commit && ctl.bitVal) |-> (lvl && cntAtRef));

  // R4: a 0 is only committed for a pulse of at least the minimum width
  assert_zero_min_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl.commit && !ctl.bitVal) |-> (cntGeMin && !lvl));

  // R5: an open window is never restarted by an edge
  assert_no_retrig_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) |=> (state != ST_MEASURE));

endmodule

// File: rtl/pulse_bit_decoder.sv
module pulse_bit_decoder
  import pulse_bit_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REF_CYCLES  = 60,
  parameter int MIN_CYCLES  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic pulseIn,
  output logic ledOn,
  output logic bitValid,
  output logic bitValue
);

  decCtl_t ctl;
  logic    lvl;
  logic    rise;
  logic    cntAtRef;
  logic    cntGeMin;

  pulse_bit_control u_control (
    .clk      (clk),
    .rst      (rst),
    .lvl      (lvl),
    .rise     (rise),
    .cntAtRef (cntAtRef),
    .cntGeMin (cntGeMin),
    .ctl      (ctl)
  );

  pulse_bit_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .REF_CYCLES  (REF_CYCLES),
    .MIN_CYCLES  (MIN_CYCLES)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .pulseIn  (pulseIn),
    .ctl      (ctl),
    .lvl      (lvl),
    .rise     (rise),
    .cntAtRef (cntAtRef),
    .cntGeMin (cntGeMin),
    .ledOn    (ledOn),
    .bitValid (bitValid),
    .bitValue (bitValue)
  );

endmodule

// File: tb/pulse_bit_decoder_bench.sv
`timescale 1ns/1ps
module pulse_bit_decoder_bench;

  localparam int SYNC = 2;
  localparam int REFW = 60;
  localparam int MINW = 10;
  localparam int GAP  = REFW + 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulseIn = 1'b0;
  logic ledOn, bitValid, bitValue;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  pulse_bit_decoder #(
    .SYNC_STAGES (SYNC),
    .REF_CYCLES  (REFW),
    .MIN_CYCLES  (MINW)
  ) u_pulse_bit_decoder (
    .clk      (clk),
    .rst      (rst),
    .pulseIn  (pulseIn),
    .ledOn    (ledOn),
    .bitValid (bitValid),
    .bitValue (bitValue)
  );

  // monitor: compares every strobe against the scoreboard
  always @(negedge clk) begin
    bit e;
    string t;
    if (!rst && bitValid && !done) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R4/R5 unexpected strobe: actual bit=%0b expected=no strobe", bitValue);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (bitValue !== e || ledOn !== e) begin
          bad++;
          $display("FAIL %s: actual bit=%0b led=%0b expected=%0b", t, bitValue, ledOn, e);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expectBit(input bit v, input string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  task automatic pulse(input int w, input int gap);
    @(negedge clk);
    pulseIn = 1'b1;
    repeat (w) @(negedge clk);
    pulseIn = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(ledOn == 1'b0, "R1 ledOn after reset", ledOn, 0);
    check(bitValid == 1'b0, "R1 bitValid after reset", bitValid, 0);

    // R3: long pulse, and its tail does not retrigger
    expectBit(1'b1, "R3 long pulse");
    pulse(150, GAP);
    check(ledOn == 1'b1, "R3 led on", ledOn, 1);

    // R2: medium pulse
    expectBit(1'b0, "R2 medium pulse");
    pulse(25, GAP);
    check(ledOn == 1'b0, "R2 led off", ledOn, 0);

    // R3 / R2: window boundary
    expectBit(1'b1, "R3 width REF+1");
    pulse(REFW + 1, GAP);
    check(ledOn == 1'b1, "R3 boundary on", ledOn, 1);
    expectBit(1'b0, "R2 width REF");
    pulse(REFW, GAP);
    check(ledOn == 1'b0, "R2 boundary off", ledOn, 0);

    // R4: runts leave a set light alone
    expectBit(1'b1, "R4 setup");
    pulse(100, GAP);
    pulse(MINW - 1, GAP);
    check(ledOn == 1'b1, "R4 runt MIN-1 ignored", ledOn, 1);
    pulse(1, GAP);
    check(ledOn == 1'b1, "R4 runt 1 ignored", ledOn, 1);
    expectBit(1'b0, "R2 width MIN");
    pulse(MINW, GAP);
    check(ledOn == 1'b0, "R2 min width decoded", ledOn, 0);

    // R5: second pulse wholly inside the window of a 0
    expectBit(1'b1, "R5 setup");
    pulse(100, GAP);
    expectBit(1'b0, "R5 first pulse");
    pulse(20, 10);
    pulse(15, GAP);
    check(ledOn == 1'b0, "R5 inner pulse ignored", ledOn, 0);

    // R5: second pulse starts inside the window and runs past it
    expectBit(1'b1, "R5 setup2");
    pulse(100, GAP);
    expectBit(1'b0, "R5 first pulse2");
    pulse(20, 10);
    pulse(100, GAP);
    check(ledOn == 1'b0, "R5 straddling pulse ignored", ledOn, 0);

    // R6: exact latency of a 1
    expectBit(1'b1, "R6 one latency");
    @(negedge clk);
    pulseIn = 1'b1;
    repeat (SYNC + REFW) @(posedge clk);
    @(negedge clk);
    check(ledOn == 1'b0 && bitValid == 1'b0, "R6 one not early", ledOn, 0);
    @(posedge clk);
    @(negedge clk);
    check(ledOn == 1'b1 && bitValid == 1'b1, "R6 one on time", ledOn, 1);
    @(negedge clk);
    check(bitValid == 1'b0, "R6 strobe one cycle", bitValid, 0);
    pulseIn = 1'b0;
    repeat (GAP) @(negedge clk);

    // R6: exact latency of a 0 (W = 20)
    expectBit(1'b0, "R6 zero latency");
    @(negedge clk);
    pulseIn = 1'b1;
    repeat (20) @(negedge clk);
    pulseIn = 1'b0;
    repeat (SYNC) @(posedge clk);
    @(negedge clk);
    check(ledOn == 1'b1, "R6 zero not early", ledOn, 1);
    @(posedge clk);
    @(negedge clk);
    check(ledOn == 1'b0 && bitValid == 1'b1, "R6 zero on time", ledOn, 0);
    repeat (GAP) @(negedge clk);

    // R7: state persists over a long idle stretch
    expectBit(1'b1, "R7 setup");
    pulse(100, GAP);
    repeat (2000) @(negedge clk);
    check(ledOn == 1'b1, "R7 held after idle", ledOn, 1);

    check(expQ.size() == 0, "R4/R5 missing strobes", expQ.size(), 0);
    finishRun();
  end

endmodule